// File: doc/BRIEF.md
# Asynchronous SRAM Write Timing Monitor

This block watches the pins of an asynchronous static RAM (address, data, the active-low and the active-high chip selects, write enable and output enable) together with the controller's own data-drive enable. A reference clock much faster than the bus samples every pin. The monitor never drives the bus. It works out each write window from three strobes of mixed polarity. A write is in progress while the active-low select is low, the active-high select is high and write enable is low. The window opens on the latest of these to arrive and closes on the earliest to leave.

Each timing interval is counted in sample ticks and compared against a limit, which is a plain input in tick units. A failed check raises a one-tick pulse on its own bit, and that bit is also held in a sticky vector until reset. The monitor also reports an address that moves inside a write window. It reports bus contention as well: the controller drives data while the memory is selected in read mode with its outputs enabled. No interface of the block carries a stream of data, so it has no valid/ready handshake. All pins are plain level signals sampled every tick.

Top module: `wr_timing_monitor`

## Requirements
- R1: At the tick a write window closes, bit 0 pulses when the ticks since the window opened are fewer than `lim_wp`.
- R2: At window close, bit 1 pulses when the ticks since both selects last became active together are fewer than `lim_cw`.
- R3: At window close, bit 2 pulses when the ticks since the last address change are fewer than `lim_aw`. A change in the closing tick counts as 0.
- R4: At window close, bit 3 pulses when the ticks since the last data change are fewer than `lim_ds`. A change in the closing tick counts as 0.
- R5: At the tick a window opens, bit 4 pulses when the ticks since the last address change are fewer than `lim_as`. A change in the same tick counts as 0.
- R6: The first address change at or after a window closes is a recovery check, and only that first change is checked. If the window was closed by the active-high select falling while neither other strobe deasserted, the interval is compared with `lim_wrb` and bit 6 pulses. Any other close uses `lim_wra` and bit 5.
- R7: When a window opens and an earlier window has opened since reset, bit 7 pulses when the ticks between the two openings are fewer than `lim_wc`.
- R8: Bit 8 pulses for an address change in a tick where the write condition held both in that tick and in the one before.
- R9: Bit 9 pulses for every tick with `drv_en` high, the active-low select low, the active-high select high, output enable low and write enable high. The memory counts as not driving while write enable is low, including a write whose active-low select falls with or after write enable, so no contention is reported then.
- R10: `viol_pulse` shows the checks of the tick sampled at a clock edge right after that edge, for one cycle. `viol_sticky` ORs in every pulse and is cleared only by reset, and both vectors are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Observed address bus |
| data | input | DATA_W | Observed data bus |
| sel_n | input | 1 | Observed active-low chip select |
| sel_hi | input | 1 | Observed active-high chip select |
| wen_n | input | 1 | Observed active-low write enable |
| oen_n | input | 1 | Observed active-low output enable |
| drv_en | input | 1 | Controller's data-drive enable |
| lim_wp | input | TICK_W | Minimum write window width |
| lim_cw | input | TICK_W | Minimum select-to-close interval |
| lim_aw | input | TICK_W | Minimum address-stable-to-close interval |
| lim_ds | input | TICK_W | Minimum data-stable-to-close interval |
| lim_as | input | TICK_W | Minimum address-stable-to-open interval |
| lim_wra | input | TICK_W | Minimum recovery after a close by select or write enable |
| lim_wrb | input | TICK_W | Minimum recovery after a close by the active-high select |
| lim_wc | input | TICK_W | Minimum open-to-open interval |
| viol_pulse | output | 10 | One-tick violation bits, positions as in R1 to R10 |
| viol_sticky | output | 10 | Accumulated violation bits |

## Verification
Bus contention and the end-of-write checks can report in the same tick. This happens when write enable rises while output enable is already low and the controller is still driving. The bench selects the memory in read mode with the drive enable high, briefly lowers write enable to open a one-tick window, then raises it again. In the closing tick it expects the width, select-to-close and contention bits together and no other bits. Separate scenarios also combine a recovery flag with the address-setup and cycle-time flags in back-to-back writes.

// File: rtl/wtm_pkg.sv
package wtm_pkg;
  localparam int NCHK  = 10;
  localparam int NSPAN = 6;

  // Violation bit positions (visible at the top-level output)
  typedef enum int unsigned {
    CK_WP = 0, CK_CW = 1, CK_AW = 2, CK_DS = 3, CK_AS = 4,
    CK_WRA = 5, CK_WRB = 6, CK_WC = 7, CK_MID = 8, CK_CONT = 9
  } chk_e;

  // Interval counters, each restarted by one bus event
  typedef enum int unsigned {
    SP_WP = 0, SP_SEL = 1, SP_ADR = 2, SP_DAT = 3, SP_REC = 4, SP_WC = 5
  } span_e;
endpackage

// File: rtl/wtm_span.sv
module wtm_span #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [TW-1:0] ticks
);
  localparam logic [TW-1:0] TOP = '1;

  // Holds ticks elapsed since the restart event; saturates, starts "long ago"
  always_ff @(posedge clk) begin
    if (!rst_n)          ticks <= TOP;
    else if (restart)    ticks <= TW'(1);
    else if (ticks != TOP) ticks <= ticks + TW'(1);
  end
endmodule

// File: rtl/wtm_edges.sv
module wtm_edges #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          sel_n,
  input  logic          sel_hi,
  input  logic          wen_n,
  input  logic          oen_n,
  input  logic          drv_en,
  output logic          wr_open,
  output logic          wr_close,
  output logic          sel_rise,
  output logic          addr_chg,
  output logic          data_chg,
  output logic          mid_chg,
  output logic          close_by_hi,
  output logic          contend
);
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;
  logic          p_seln, p_selhi, p_wen;
  logic          sel_now, sel_was, wr_now, wr_was;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_addr  <= '0;
      p_data  <= '0;
      p_seln  <= 1'b1;
      p_selhi <= 1'b0;
      p_wen   <= 1'b1;
    end else begin
      p_addr  <= addr;
      p_data  <= data;
      p_seln  <= sel_n;
      p_selhi <= sel_hi;
      p_wen   <= wen_n;
    end
  end

  always_comb begin
    sel_now  = !sel_n && sel_hi;
    sel_was  = !p_seln && p_selhi;
    wr_now   = sel_now && !wen_n;
    wr_was   = sel_was && !p_wen;
    wr_open  = wr_now && !wr_was;
    wr_close = !wr_now && wr_was;
    sel_rise = sel_now && !sel_was;
    addr_chg = (addr != p_addr);
    data_chg = (data != p_data);
    mid_chg  = addr_chg && wr_now && wr_was;
    // Class B only when the active-high select alone ended the window
    close_by_hi = wr_close && p_selhi && !sel_hi
                  && !(sel_n && !p_seln) && !(wen_n && !p_wen);
    contend  = drv_en && sel_now && !oen_n && wen_n;
  end
endmodule

// File: rtl/wtm_flags.sv
module wtm_flags #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  output logic [N-1:0] pulse,
  output logic [N-1:0] sticky
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse  <= '0;
      sticky <= '0;
    end else begin
      pulse  <= hit;
      sticky <= sticky | hit;
    end
  end
endmodule

// File: rtl/wr_timing_monitor.sv
module wr_timing_monitor
  import wtm_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int TICK_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              wen_n,
  input  logic              oen_n,
  input  logic              drv_en,
  input  logic [TICK_W-1:0] lim_wp,
  input  logic [TICK_W-1:0] lim_cw,
  input  logic [TICK_W-1:0] lim_aw,
  input  logic [TICK_W-1:0] lim_ds,
  input  logic [TICK_W-1:0] lim_as,
  input  logic [TICK_W-1:0] lim_wra,
  input  logic [TICK_W-1:0] lim_wrb,
  input  logic [TICK_W-1:0] lim_wc,
  output logic [NCHK-1:0]   viol_pulse,
  output logic [NCHK-1:0]   viol_sticky
);
  logic wr_open, wr_close, sel_rise, addr_chg, data_chg, mid_chg, close_by_hi, contend;
  logic [NSPAN-1:0]  restart_v;
  logic [TICK_W-1:0] span [NSPAN];
  logic [NCHK-1:0]   hit;
  logic              rec_pend, rec_cls_b, open_seen;
  logic [TICK_W-1:0] adr_age, dat_age, rec_gap;
  logic              rec_live, rec_b;

  wtm_edges #(.AW(ADDR_W), .DW(DATA_W)) u_edges (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data(data),
    .sel_n(sel_n), .sel_hi(sel_hi), .wen_n(wen_n), .oen_n(oen_n), .drv_en(drv_en),
    .wr_open(wr_open), .wr_close(wr_close), .sel_rise(sel_rise),
    .addr_chg(addr_chg), .data_chg(data_chg), .mid_chg(mid_chg),
    .close_by_hi(close_by_hi), .contend(contend)
  );

  always_comb begin
    restart_v         = '0;
    restart_v[SP_WP]  = wr_open;
    restart_v[SP_SEL] = sel_rise;
    restart_v[SP_ADR] = addr_chg;
    restart_v[SP_DAT] = data_chg;
    restart_v[SP_REC] = wr_close;
    restart_v[SP_WC]  = wr_open;
  end

  for (genvar g = 0; g < NSPAN; g++) begin : g_span
    wtm_span #(.TW(TICK_W)) u_span (
      .clk(clk), .rst_n(rst_n), .restart(restart_v[g]), .ticks(span[g])
    );
  end

  // Recovery bookkeeping: one pending check per closed window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_pend  <= 1'b0;
      rec_cls_b <= 1'b0;
      open_seen <= 1'b0;
    end else begin
      open_seen <= open_seen | wr_open;
      if (wr_close && !addr_chg) begin
        rec_pend  <= 1'b1;
        rec_cls_b <= close_by_hi;
      end else if (addr_chg) begin
        rec_pend  <= 1'b0;
      end
    end
  end

  always_comb begin
    adr_age  = addr_chg ? '0 : span[SP_ADR];
    dat_age  = data_chg ? '0 : span[SP_DAT];
    rec_live = wr_close || rec_pend;
    rec_gap  = wr_close ? '0 : span[SP_REC];
    rec_b    = wr_close ? close_by_hi : rec_cls_b;
    hit      = '0;
    if (wr_close) begin
      hit[CK_WP] = span[SP_WP]  < lim_wp;
      hit[CK_CW] = span[SP_SEL] < lim_cw;
      hit[CK_AW] = adr_age      < lim_aw;
      hit[CK_DS] = dat_age      < lim_ds;
    end
    if (wr_open) begin
      hit[CK_AS] = adr_age < lim_as;
      hit[CK_WC] = open_seen && (span[SP_WC] < lim_wc);
    end
    if (addr_chg && rec_live) begin
      if (rec_b) hit[CK_WRB] = rec_gap < lim_wrb;
      else       hit[CK_WRA] = rec_gap < lim_wra;
    end
    hit[CK_MID]  = mid_chg;
    hit[CK_CONT] = contend;
  end

  wtm_flags #(.N(NCHK)) u_flags (
    .clk(clk), .rst_n(rst_n), .hit(hit), .pulse(viol_pulse), .sticky(viol_sticky)
  );
endmodule

// File: rtl/wtm_chk.sv
module wtm_chk #(
  parameter int NCHK = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sel_n,
  input logic            sel_hi,
  input logic            wen_n,
  input logic            oen_n,
  input logic            drv_en,
  input logic [NCHK-1:0] viol_pulse,
  input logic [NCHK-1:0] viol_sticky
);
  // R9: read-mode drive by the controller is reported next cycle
  a_r9_contention_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && !sel_n && sel_hi && !oen_n && wen_n) |=> viol_pulse[9]);

  // R9: no contention report while write enable is low
  a_r9_quiet_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wen_n |=> !viol_pulse[9]);

  // R10: sticky bits never clear outside reset
  a_r10_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((viol_sticky & $past(viol_sticky)) == $past(viol_sticky)));

  // R10: every pulse is present in the sticky vector
  a_r10_pulse_in_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|viol_pulse) |-> ((viol_sticky & viol_pulse) == viol_pulse));

  // R8: a mid-write report only follows a tick with the write condition true
  a_r8_mid_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse[8] |-> $past(!sel_n && sel_hi && !wen_n));

  // R1: width report only follows a tick where the write condition was false
  a_r1_width_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse[0] |-> !$past(!sel_n && sel_hi && !wen_n));
endmodule

bind wr_timing_monitor wtm_chk #(.NCHK(wtm_pkg::NCHK)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_hi(sel_hi), .wen_n(wen_n),
  .oen_n(oen_n), .drv_en(drv_en), .viol_pulse(viol_pulse), .viol_sticky(viol_sticky)
);

// File: tb/sim_wr_timing_monitor.sv
module sim_wr_timing_monitor;
  localparam logic [9:0] B_WP = 10'h001, B_CW = 10'h002, B_AW = 10'h004, B_DS = 10'h008,
                         B_AS = 10'h010, B_WRA = 10'h020, B_WRB = 10'h040, B_WC = 10'h080,
                         B_MID = 10'h100, B_CONT = 10'h200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  data = '0;
  logic        sel_n = 1'b1, sel_hi = 1'b0, wen_n = 1'b1, oen_n = 1'b1, drv_en = 1'b0;
  logic [11:0] lim_wp = 12'd5, lim_cw = 12'd6, lim_aw = 12'd7, lim_ds = 12'd4;
  logic [11:0] lim_as = 12'd0, lim_wra = 12'd0, lim_wrb = 12'd0, lim_wc = 12'd12;
  logic [9:0]  viol_pulse, viol_sticky;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic mon_on = 1'b0;

  typedef struct { int c; logic [9:0] v; } exp_t;
  exp_t q[$];

  wr_timing_monitor u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data(data), .sel_n(sel_n), .sel_hi(sel_hi),
    .wen_n(wen_n), .oen_n(oen_n), .drv_en(drv_en), .lim_wp(lim_wp), .lim_cw(lim_cw),
    .lim_aw(lim_aw), .lim_ds(lim_ds), .lim_as(lim_as), .lim_wra(lim_wra),
    .lim_wrb(lim_wrb), .lim_wc(lim_wc), .viol_pulse(viol_pulse), .viol_sticky(viol_sticky)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic string req_of(input logic [9:0] diff);
    if (diff[0]) return "R1";
    if (diff[1]) return "R2";
    if (diff[2]) return "R3";
    if (diff[3]) return "R4";
    if (diff[4]) return "R5";
    if (diff[5] || diff[6]) return "R6";
    if (diff[7]) return "R7";
    if (diff[8]) return "R8";
    return "R9";
  endfunction

  // Driver side: expected pulse vector for a given tick; same-tick items merge
  task automatic push(input int c, input logic [9:0] v);
    if (v == '0) return;
    if (q.size() > 0 && q[$].c == c) q[$].v = q[$].v | v;
    else q.push_back('{c, v});
  endtask

  // Monitor: compare the pulse vector every cycle against the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      logic [9:0] exp_v;
      exp_v = '0;
      if (q.size() > 0 && q[0].c == cyc) begin
        exp_v = q[0].v;
        void'(q.pop_front());
      end
      n_cmp++;
      if (viol_pulse !== exp_v) begin
        n_bad++;
        $display("FAIL %s tick %0d: actual=%h expected=%h", req_of(viol_pulse ^ exp_v),
                 cyc, viol_pulse, exp_v);
      end
    end
  end

  task automatic check_vec(input string tag, input logic [9:0] act, input logic [9:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic wr_cycle(input logic [12:0] a, input logic [7:0] d, input int pre,
                          input int wp, input int post,
                          input logic [9:0] e0, input logic [9:0] es, input logic [9:0] ee);
    @(negedge clk);
    addr = a; data = d; sel_n = 1'b0; sel_hi = 1'b1; drv_en = 1'b1;
    push(cyc + 1, e0);
    repeat (pre) @(negedge clk);
    wen_n = 1'b0;
    push(cyc + 1, es);
    repeat (wp) @(negedge clk);
    wen_n = 1'b1;
    push(cyc + 1, ee);
    repeat (post) @(negedge clk);
    sel_n = 1'b1; sel_hi = 1'b0; drv_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check_vec("R10 reset pulse", viol_pulse, '0);
    check_vec("R10 reset sticky", viol_sticky, '0);
    mon_on = 1'b1;

    // clean write: no flags
    wr_cycle(13'd1, 8'h11, 2, 6, 1, '0, '0, '0);
    idle(5);
    // R1 short width, R3 address too fresh
    wr_cycle(13'd2, 8'h22, 3, 3, 1, '0, '0, B_WP | B_AW);
    idle(5);
    // R7 openings 11 ticks apart, R3 again
    wr_cycle(13'd3, 8'h33, 1, 5, 1, '0, B_WC, B_AW);
    idle(10);
    // R2 select-to-close 5 ticks; write enable low with select (R9 quiet)
    wr_cycle(13'd3, 8'h44, 0, 5, 1, '0, '0, B_CW);
    idle(10);

    // R4: data moves 2 ticks before close
    @(negedge clk); addr = 13'd5; data = 8'h55; sel_n = 1'b0; sel_hi = 1'b1; drv_en = 1'b1;
    @(negedge clk); wen_n = 1'b0;
    idle(4); data = 8'h56;
    idle(2); wen_n = 1'b1; push(cyc + 1, B_DS);
    @(negedge clk); sel_n = 1'b1; sel_hi = 1'b0; drv_en = 1'b0;
    idle(10);

    // R8 address moves inside the window; R3 follows at close
    @(negedge clk); addr = 13'd6; data = 8'h66; sel_n = 1'b0; sel_hi = 1'b1; drv_en = 1'b1;
    @(negedge clk); wen_n = 1'b0;
    idle(3); addr = 13'd7; push(cyc + 1, B_MID);
    idle(3); wen_n = 1'b1; push(cyc + 1, B_AW);
    @(negedge clk); sel_n = 1'b1; sel_hi = 1'b0; drv_en = 1'b0;
    idle(10);

    lim_as = 12'd2; lim_wra = 12'd3; lim_wrb = 12'd3;
    idle(2);
    wr_cycle(13'd8, 8'h77, 2, 6, 1, '0, '0, '0);
    // R6 class A recovery 2 ticks, R5 setup 1 tick, R7 openings 9 ticks apart
    wr_cycle(13'd9, 8'h88, 1, 6, 1, B_WRA, B_AS | B_WC, '0);
    idle(10);

    // R6 class B: window closed by the active-high select, address moves 1 tick later
    @(negedge clk); addr = 13'd10; data = 8'h99; sel_n = 1'b0; sel_hi = 1'b1; drv_en = 1'b1;
    idle(2); wen_n = 1'b0;
    idle(6); sel_hi = 1'b0;
    @(negedge clk); addr = 13'd11; push(cyc + 1, B_WRB);
    @(negedge clk); wen_n = 1'b1; sel_n = 1'b1; drv_en = 1'b0;
    idle(10);

    // R9 contention, then a one-tick window closing together with contention
    @(negedge clk); sel_n = 1'b0; sel_hi = 1'b1; oen_n = 1'b0; drv_en = 1'b1; push(cyc + 1, B_CONT);
    @(negedge clk); push(cyc + 1, B_CONT);
    @(negedge clk); push(cyc + 1, B_CONT);
    @(negedge clk); wen_n = 1'b0;
    @(negedge clk); wen_n = 1'b1; push(cyc + 1, B_WP | B_CW | B_CONT);
    @(negedge clk); drv_en = 1'b0;
    @(negedge clk); sel_n = 1'b1; sel_hi = 1'b0; oen_n = 1'b1;
    idle(5);

    mon_on = 1'b0;
    check_vec("R10 sticky accumulates all checks", viol_sticky, 10'h3FF);
    n_cmp++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R10 scoreboard leftovers: actual=%0d expected=0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule